// File: doc/BRIEF.md
# Negate-and-Subtract Accumulator Processor

A small stored-program processor built around one signed 32-bit accumulator and a private store of 32 words of 32 bits. A 5-bit instruction counter names the word that was last executed. Each instruction cycle first steps the counter and then fetches from the new value. Arithmetic consists only of loading a negated word and subtracting a word. Control flow uses indirect jumps, which take their target from a store word either as an absolute value or as an offset added to the counter, and a skip that passes over one instruction when the accumulator is negative. A stop instruction returns the core to the halted state.

While the core is halted, a debug port owns the store. It can deposit a word at once and examine a word with a one-cycle read latency. It can also overwrite the counter. A pulse on `run` starts execution from the counter as it stands. An optional breakpoint halts the core whenever the counter equals a chosen address at the start of an instruction cycle. The breakpoint is not tested on the first cycle after a start, so execution can resume from a breakpoint.

Top module: `nc_core`

## Requirements
- R1: After reset `halted` is 1, `ci_o` is 0 and `acc_o` is 0, and the core stays halted until `run` is sampled high.
- R2: Every instruction takes exactly three clocks: increment and fetch, decode, execute. The counter is incremented modulo 32 before the fetch, and the word at the new count is the instruction. From the clock edge that samples `run`, a program of n instructions that ends on a stop raises `halted` after 3n+1 edges.
- R3: The opcode is instruction bits 15:13 and the operand address is bits 4:0. All other instruction bits have no effect.
- R4: Opcode 0 loads the counter with the low 5 bits of the addressed word. Opcode 1 adds the low 5 bits of the addressed word to the counter, modulo 32. The next instruction comes from that value plus one.
- R5: Opcode 2 loads the accumulator with the two's-complement negation of the addressed word. Opcode 3 writes the accumulator into the addressed word.
- R6: Opcodes 4 and 5 both subtract the addressed word from the accumulator, modulo 2^32.
- R7: Opcode 6 adds one to the counter when accumulator bit 31 is set, which skips the next instruction. Otherwise it changes nothing.
- R8: Opcode 7 halts the core. The counter is left pointing at the stop instruction.
- R9: At the start of an instruction cycle, if `brk_en` is 1 and the counter equals `brk_addr`, the core halts without incrementing the counter. This test is skipped on the first instruction cycle after a start. A halt caused by the breakpoint is seen 3n+2 edges after the edge that samples `run`.
- R10: While halted, `dbg_we` writes `dbg_wdata` to `dbg_addr` at the next edge. `dbg_rdata` shows the word at `dbg_addr` one clock after the address is presented. `dbg_ci_we` loads the counter, and `run` takes priority over it. While the core is running, `dbg_we` and `dbg_ci_we` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Starts execution when sampled high while halted |
| halted | output | 1 | High while the core is stopped |
| brk_en | input | 1 | Enables the breakpoint comparison |
| brk_addr | input | 5 | Breakpoint counter value |
| dbg_we | input | 1 | Debug store write strobe (halted only) |
| dbg_addr | input | 5 | Debug store address |
| dbg_wdata | input | 32 | Debug store write data |
| dbg_rdata | output | 32 | Store word read one clock after `dbg_addr` |
| dbg_ci_we | input | 1 | Debug counter load strobe (halted only) |
| dbg_ci_wdata | input | 5 | Debug counter load value |
| ci_o | output | 5 | Instruction counter |
| acc_o | output | 32 | Accumulator |

## Verification
The store and the counter are loaded through the debug port. The bench then pulses `run` and counts clock edges until `halted` rises, and compares that count with the 3n+1 or 3n+2 that its own instruction-level model predicts. After the halt the bench compares the counter and the accumulator with the model. It then reads back every store word, sampling `dbg_rdata` one clock after each address is applied. All inputs change on falling edges and all outputs are sampled there, so each result is read one full half-period after the edge that produced it.

// File: rtl/nc_pkg.sv
package nc_pkg;
  localparam int OP_LSB = 13;
  localparam int OP_W   = 3;

  typedef enum logic [2:0] {
    OP_JMP    = 3'd0,
    OP_JREL   = 3'd1,
    OP_LDNEG  = 3'd2,
    OP_STO    = 3'd3,
    OP_SUB    = 3'd4,
    OP_SUBALT = 3'd5,
    OP_SKN    = 3'd6,
    OP_HALT   = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FETCH  = 2'd1,
    ST_DECODE = 2'd2,
    ST_EXEC   = 2'd3
  } state_e;
endpackage

// File: rtl/nc_store.sv
module nc_store #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // single port, registered read, read-before-write
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/nc_exec.sv
module nc_exec
  import nc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  opcode_e           op,
  input  logic [ADDR_W-1:0] ci,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  output logic [ADDR_W-1:0] ci_nx,
  output logic [DATA_W-1:0] acc_nx,
  output logic              st_we,
  output logic              stop
);
  function automatic logic [DATA_W-1:0] f_negate(input logic [DATA_W-1:0] w);
    return '0 - w;
  endfunction

  function automatic logic [DATA_W-1:0] f_minus(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] w);
    return a - w;
  endfunction

  function automatic logic [ADDR_W-1:0] f_hop(input logic [ADDR_W-1:0] c,
                                              input logic [ADDR_W-1:0] d);
    return c + d;
  endfunction

  always_comb begin
    ci_nx  = ci;
    acc_nx = acc;
    st_we  = 1'b0;
    stop   = 1'b0;
    unique case (op)
      OP_JMP:            ci_nx  = opnd[ADDR_W-1:0];
      OP_JREL:           ci_nx  = f_hop(ci, opnd[ADDR_W-1:0]);
      OP_LDNEG:          acc_nx = f_negate(opnd);
      OP_STO:            st_we  = 1'b1;
      OP_SUB, OP_SUBALT: acc_nx = f_minus(acc, opnd);
      OP_SKN:            if (acc[DATA_W-1]) ci_nx = f_hop(ci, ADDR_W'(1));
      OP_HALT:           stop   = 1'b1;
      default:           stop   = 1'b0;
    endcase
  end
endmodule

// File: rtl/nc_core.sv
module nc_core
  import nc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  output logic              halted,
  input  logic              brk_en,
  input  logic [ADDR_W-1:0] brk_addr,
  input  logic              dbg_we,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata,
  input  logic              dbg_ci_we,
  input  logic [ADDR_W-1:0] dbg_ci_wdata,
  output logic [ADDR_W-1:0] ci_o,
  output logic [DATA_W-1:0] acc_o
);
  state_e            state_q;
  logic [ADDR_W-1:0] ci_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] pi_q;
  logic              first_q;

  logic              st_we;
  logic [ADDR_W-1:0] st_addr;
  logic [DATA_W-1:0] st_wdata;
  logic [DATA_W-1:0] st_rdata;

  opcode_e           ex_op;
  logic [ADDR_W-1:0] ex_ci_nx;
  logic [DATA_W-1:0] ex_acc_nx;
  logic              ex_st_we;
  logic              ex_stop;

  // named events for the assertions
  logic              brk_hit;
  logic              in_exec;
  logic [ADDR_W-1:0] ci_inc;

  assign halted   = (state_q == ST_IDLE);
  assign in_exec  = (state_q == ST_EXEC);
  assign brk_hit  = (state_q == ST_FETCH) && brk_en && !first_q && (ci_q == brk_addr);
  assign ci_inc   = ci_q + 1'b1;
  assign ex_op    = opcode_e'(pi_q[OP_LSB +: OP_W]);

  nc_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk  (clk),
    .we   (st_we),
    .addr (st_addr),
    .wdata(st_wdata),
    .rdata(st_rdata)
  );

  nc_exec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_exec (
    .op    (ex_op),
    .ci    (ci_q),
    .acc   (acc_q),
    .opnd  (st_rdata),
    .ci_nx (ex_ci_nx),
    .acc_nx(ex_acc_nx),
    .st_we (ex_st_we),
    .stop  (ex_stop)
  );

  // store port: debug owns it while halted, sequencer otherwise
  always_comb begin
    st_we    = 1'b0;
    st_addr  = dbg_addr;
    st_wdata = dbg_wdata;
    unique case (state_q)
      ST_IDLE:   st_we   = dbg_we;
      ST_FETCH:  st_addr = ci_inc;
      ST_DECODE: st_addr = st_rdata[ADDR_W-1:0];
      ST_EXEC: begin
        st_addr  = pi_q[ADDR_W-1:0];
        st_we    = ex_st_we;
        st_wdata = acc_q;
      end
      default:   st_we   = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ci_q    <= '0;
      acc_q   <= '0;
      pi_q    <= '0;
      first_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (run) begin
            state_q <= ST_FETCH;
            first_q <= 1'b1;
          end else if (dbg_ci_we) begin
            ci_q <= dbg_ci_wdata;
          end
        end
        ST_FETCH: begin
          first_q <= 1'b0;
          if (brk_hit) begin
            state_q <= ST_IDLE;
          end else begin
            ci_q    <= ci_inc;
            state_q <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          pi_q    <= st_rdata;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          ci_q    <= ex_ci_nx;
          acc_q   <= ex_acc_nx;
          state_q <= ex_stop ? ST_IDLE : ST_FETCH;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dbg_rdata = st_rdata;
  assign ci_o      = ci_q;
  assign acc_o     = acc_q;

  // R2: a fetch without a breakpoint steps the counter by one
  a_r2_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH && !brk_hit) |=> (ci_q == ADDR_W'($past(ci_q) + 1'b1)));

  // R6: both subtract codes reduce the accumulator by the operand
  a_r6_subtract: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && (ex_op == OP_SUB || ex_op == OP_SUBALT))
      |=> (acc_q == $past(acc_q) - $past(st_rdata)));

  // R7: skip with a non-negative accumulator leaves the counter alone
  a_r7_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && ex_op == OP_SKN && !acc_q[DATA_W-1]) |=> $stable(ci_q));

  // R8: a stop instruction halts the core
  a_r8_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && ex_stop) |=> halted);

  // R9: a breakpoint halts without stepping the counter
  a_r9_brk_halts: assert property (@(posedge clk) disable iff (!rst_n)
    brk_hit |=> (halted && $stable(ci_q)));

  // R10: while halted with no start and no counter load, state holds
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !run && !dbg_ci_we) |=> (halted && $stable(ci_q) && $stable(acc_q)));
endmodule

// File: tb/test_nc_core.sv
module test_nc_core;
  localparam int DW = 32;
  localparam int AW = 5;
  localparam int MAXSTEPS = 100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run = 1'b0;
  logic          halted;
  logic          brk_en = 1'b0;
  logic [AW-1:0] brk_addr = '0;
  logic          dbg_we = 1'b0;
  logic [AW-1:0] dbg_addr = '0;
  logic [DW-1:0] dbg_wdata = '0;
  logic [DW-1:0] dbg_rdata;
  logic          dbg_ci_we = 1'b0;
  logic [AW-1:0] dbg_ci_wdata = '0;
  logic [AW-1:0] ci_o;
  logic [DW-1:0] acc_o;

  always #4 clk = ~clk;

  nc_core #(.DATA_W(DW), .ADDR_W(AW)) i_nc_core (
    .clk(clk), .rst_n(rst_n), .run(run), .halted(halted),
    .brk_en(brk_en), .brk_addr(brk_addr),
    .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
    .dbg_rdata(dbg_rdata), .dbg_ci_we(dbg_ci_we), .dbg_ci_wdata(dbg_ci_wdata),
    .ci_o(ci_o), .acc_o(acc_o)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // model state
  logic [DW-1:0] m_mem [32];
  logic [AW-1:0] m_ci;
  logic [DW-1:0] m_acc;
  logic [DW-1:0] t_mem [32];
  logic [AW-1:0] t_ci;
  logic [DW-1:0] t_acc;
  int            last_edges;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mk(input int op, input int a, input logic [23:0] j);
    logic [2:0] o;
    logic [4:0] ad;
    o = 3'(op);
    ad = 5'(a);
    return {j[15:0], o, j[23:16], ad};
  endfunction

  // instruction-level reference; returns edge count from the run edge
  task automatic model_run(output int edges, output bit done);
    bit first = 1'b1;
    logic [DW-1:0] ins, w;
    logic [2:0] op;
    edges = 1;
    done = 1'b0;
    for (int s = 0; s < MAXSTEPS; s++) begin
      if (!first && brk_en && t_ci == brk_addr) begin
        edges += 1;
        done = 1'b1;
        return;
      end
      first = 1'b0;
      t_ci = t_ci + 5'd1;
      ins = t_mem[t_ci];
      op = ins[15:13];
      w = t_mem[ins[4:0]];
      edges += 3;
      case (op)
        3'd0: t_ci = w[4:0];
        3'd1: t_ci = t_ci + w[4:0];
        3'd2: t_acc = ~w + 32'd1;
        3'd3: t_mem[ins[4:0]] = t_acc;
        3'd4, 3'd5: t_acc = t_acc + ~w + 32'd1;
        3'd6: if (t_acc[31]) t_ci = t_ci + 5'd1;
        default: begin done = 1'b1; return; end
      endcase
    end
  endtask

  task automatic deposit(input int a, input logic [DW-1:0] v);
    @(negedge clk);
    dbg_we = 1'b1; dbg_addr = 5'(a); dbg_wdata = v;
    @(posedge clk);
    @(negedge clk);
    dbg_we = 1'b0;
  endtask

  task automatic set_ci(input logic [AW-1:0] v);
    @(negedge clk);
    dbg_ci_we = 1'b1; dbg_ci_wdata = v;
    @(posedge clk);
    @(negedge clk);
    dbg_ci_we = 1'b0;
  endtask

  task automatic load_all();
    for (int i = 0; i < 32; i++) deposit(i, m_mem[i]);
    set_ci(m_ci);
  endtask

  // start, count edges to halt, compare with the model
  task automatic go(input bit spoil, input string req);
    int cnt;
    int edges;
    bit done;
    int bad;
    logic [DW-1:0] badv, bade;
    for (int i = 0; i < 32; i++) t_mem[i] = m_mem[i];
    t_ci = m_ci;
    t_acc = m_acc;
    model_run(edges, done);
    @(negedge clk);
    run = 1'b1;
    @(posedge clk);
    cnt = 1;
    @(negedge clk);
    run = 1'b0;
    chk({req, " R2 running after start"}, {31'd0, halted}, 32'd0);
    if (spoil) begin
      dbg_we = 1'b1; dbg_addr = 5'($urandom); dbg_wdata = $urandom;
      dbg_ci_we = 1'b1; dbg_ci_wdata = 5'($urandom);
    end
    while (!halted && cnt < 4 * MAXSTEPS) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      dbg_we = 1'b0;
      dbg_ci_we = 1'b0;
    end
    last_edges = cnt;
    chk({req, " R2 edges to halt"}, 32'(cnt), 32'(edges));
    chk({req, " R4 counter"}, {27'd0, ci_o}, {27'd0, t_ci});
    chk({req, " R6 accumulator"}, acc_o, t_acc);
    bad = -1; badv = '0; bade = '0;
    for (int i = 0; i < 32; i++) begin
      dbg_addr = 5'(i);
      @(posedge clk);
      @(negedge clk);
      if (dbg_rdata !== t_mem[i] && bad < 0) begin
        bad = i; badv = dbg_rdata; bade = t_mem[i];
      end
    end
    chk({req, " R10 store readback"}, badv, bade);
    for (int i = 0; i < 32; i++) m_mem[i] = t_mem[i];
    m_ci = t_ci;
    m_acc = t_acc;
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 halted after reset", {31'd0, halted}, 32'd1);
    chk("R1 counter after reset", {27'd0, ci_o}, 32'd0);
    chk("R1 accumulator after reset", acc_o, 32'd0);
    repeat (5) @(negedge clk);
    chk("R1 stays halted without run", {31'd0, halted}, 32'd1);
    m_ci = '0;
    m_acc = '0;

    // directed program: R3 junk bits, R4 jumps, R5, R6 alias, R7 skip, R8 stop
    for (int i = 0; i < 32; i++) m_mem[i] = '0;
    m_mem[1]  = mk(2, 20, 24'hA5_C3_F1);
    m_mem[2]  = mk(5, 21, 24'h3C_00_77);
    m_mem[3]  = mk(3, 22, 24'hFF_FF_FF);
    m_mem[4]  = mk(6, 9, 24'h12_34_56);
    m_mem[5]  = mk(7, 0, 24'h0);
    m_mem[6]  = mk(1, 23, 24'h81_18_00);
    m_mem[9]  = mk(0, 24, 24'h00_7E_11);
    m_mem[12] = mk(7, 31, 24'hDE_AD_BE);
    m_mem[20] = 32'd5;
    m_mem[21] = 32'd3;
    m_mem[23] = 32'h0000_0042;
    m_mem[24] = 32'hFFFF_FFEB;
    m_ci = 5'd0;
    load_all();
    go(1'b0, "directed");
    chk("R4 jump target truncated", {27'd0, ci_o}, 32'd12);
    chk("R6 alias subtract result", acc_o, 32'hFFFF_FFF8);
    chk("R2 seven instructions take 22 edges", 32'(last_edges), 32'd22);
    chk("R8 halted after stop", {31'd0, halted}, 32'd1);
    chk("R5 stored accumulator", m_mem[22], 32'hFFFF_FFF8);

    // breakpoint program: R9
    for (int i = 0; i < 32; i++) m_mem[i] = '0;
    m_mem[1]  = mk(2, 30, 24'h0);
    m_mem[2]  = mk(6, 0, 24'h0);
    m_mem[3]  = mk(6, 0, 24'h0);
    m_mem[4]  = mk(4, 31, 24'h0);
    m_mem[5]  = mk(7, 0, 24'h0);
    m_mem[31] = 32'hFFFF_FFFE;
    m_ci = 5'd0;
    load_all();
    brk_en = 1'b1;
    brk_addr = 5'd3;
    go(1'b0, "breakpoint");
    chk("R9 breakpoint counter", {27'd0, ci_o}, 32'd3);
    chk("R9 breakpoint edges", 32'(last_edges), 32'd11);
    chk("R7 no skip on zero accumulator", acc_o, 32'd0);
    go(1'b0, "resume");
    chk("R9 resume past breakpoint", {27'd0, ci_o}, 32'd5);
    chk("R6 subtract negative operand", acc_o, 32'd2);
    chk("R9 resume edges", 32'(last_edges), 32'd7);
    brk_en = 1'b0;

    // random programs, half with debug writes while running (R10)
    begin
      int runs = 0;
      for (int tries = 0; tries < 3000 && runs < 16; tries++) begin
        int edges;
        bit done;
        logic [DW-1:0] cand [32];
        logic [AW-1:0] cci;
        logic          cbe;
        logic [AW-1:0] cba;
        for (int i = 0; i < 32; i++) begin
          if ($urandom_range(0, 2) == 0) cand[i] = $urandom;
          else cand[i] = mk($urandom_range(0, 7), $urandom_range(0, 31), 24'($urandom));
        end
        cci = 5'($urandom);
        cbe = ($urandom_range(0, 3) == 0);
        cba = 5'($urandom);
        for (int i = 0; i < 32; i++) t_mem[i] = cand[i];
        t_ci = cci;
        t_acc = m_acc;
        brk_en = cbe;
        brk_addr = cba;
        model_run(edges, done);
        if (done) begin
          for (int i = 0; i < 32; i++) m_mem[i] = cand[i];
          m_ci = cci;
          load_all();
          go(runs[0], runs[0] ? "random R10 ignored-while-running" : "random R3");
          runs++;
        end
      end
      chk("R2 random programs completed", 32'(runs), 32'd16);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog R2 actual=running expected=halted");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule